// File: doc/BRIEF.md
# Programmable Raster Sync Timing Generator

This block produces the horizontal and vertical synchronisation signals for a video raster from a run-time mode description. A horizontal counter advances on every pixel clock and repeats once per line. A vertical counter advances only when the horizontal counter completes a line. Both sync outputs are active low. Each sync pulse starts at count 0 of its counter and lasts for a programmable length. A one-cycle strobe marks the pixel position where a downstream pixel engine should begin scanning out the line. The block also outputs the current line number.

Each mode is given as three values per axis: a period total, a sync start and a sync end. The block uses two differences of these values. The sync pulse length is end minus start. The scanout-start position is the line total minus the horizontal sync end. The mode inputs are copied into internal registers on every clock while the generator is disabled. Once it runs, those copies are frozen, so the mode inputs may change freely without disturbing the raster. A two-state controller sets the behaviour. IDLE holds the counters at zero, keeps both syncs deasserted and loads the mode. RUN advances the counters. The transition IDLE to RUN (named `start`) happens at a clock edge that samples `enable` high. The transition RUN to IDLE (named `halt`) happens at an edge that samples it low. The default mode parameters are 800 pixels per line, horizontal sync 656 to 720, 497 lines per frame and vertical sync 481 to 484. These give a 64-pixel hsync, a scanout strobe at pixel 80 and a 3-line vsync.

Top module: `vga_sync_gen`

## Requirements
- R1: While `rst_n` is low and after its release with `enable` low, `hsync_n` and `vsync_n` are 1, `scan_start` is 0 and `line_num` is 0.
- R2: While `enable` is low, the outputs keep the idle values of R1 from the cycle after the edge that first sampled it low. Mode inputs are loaded on every such edge.
- R3: Mode inputs changed while the generator runs have no effect on any output until the next halt and start.
- R4: Pixel 0 of line 0 is the cycle after the edge that first samples `enable` high (start). Pixel index p = t mod htotal, where t counts cycles from that one. `hsync_n` is 0 exactly when p < (hs_end − hs_start).
- R5: `scan_start` is 1 for exactly one cycle per line, at pixel p = htotal − hs_end.
- R6: `line_num` equals floor(t / htotal) mod vtotal. It changes only on the cycle that follows the last pixel of a line, and it wraps from vtotal−1 to 0.
- R7: `vsync_n` is 0 exactly when `line_num` < (vs_end − vs_start), and it is constant within a line.
- R8: A halt returns the outputs to idle on the next cycle. A later start begins again at pixel 0 of line 0, whatever the earlier position was.
- R9: With the default mode values (800/656/720, 497/481/484), hsync is low for 64 pixels of each line and `scan_start` fires at pixel 80.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run request; low holds the generator idle and loads the mode |
| cfg_htotal | input | HW | Pixels per line |
| cfg_hs_start | input | HW | Horizontal sync start position |
| cfg_hs_end | input | HW | Horizontal sync end position |
| cfg_vtotal | input | VW | Lines per frame |
| cfg_vs_start | input | VW | Vertical sync start line |
| cfg_vs_end | input | VW | Vertical sync end line |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| line_num | output | VW | Current line number |
| scan_start | output | 1 | One-cycle scanout-start strobe |

## Verification
The bench sweeps small modes through full frames and goes after the edges of each counter. If a comparison is off by one, the sync pulse is one pixel too long or too short, or the wrap comes one pixel late, and the arithmetic model flags it on the first line. If the vertical counter advances on the wrong condition, `line_num` and `vsync_n` drift away from floor(t/htotal) during the first line. The bench changes the mode inputs in the middle of a run. A design that failed to freeze its mode copies would change its line period at that point. The bench also halts mid-frame and starts again. A design that failed to clear its counters would resume from a non-zero line.

// File: rtl/vsg_pkg.sv
package vsg_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } vsg_state_e;
endpackage

// File: rtl/vsg_mode_regs.sv
module vsg_mode_regs #(
    parameter int HW           = 12,
    parameter int VW           = 11,
    parameter int DEF_HTOTAL   = 800,
    parameter int DEF_HS_START = 656,
    parameter int DEF_HS_END   = 720,
    parameter int DEF_VTOTAL   = 497,
    parameter int DEF_VS_START = 481,
    parameter int DEF_VS_END   = 484
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [HW-1:0] in_htotal,
    input  logic [HW-1:0] in_hs_start,
    input  logic [HW-1:0] in_hs_end,
    input  logic [VW-1:0] in_vtotal,
    input  logic [VW-1:0] in_vs_start,
    input  logic [VW-1:0] in_vs_end,
    output logic [HW-1:0] htotal_q,
    output logic [HW-1:0] hs_width,
    output logic [HW-1:0] scan_pos,
    output logic [VW-1:0] vtotal_q,
    output logic [VW-1:0] vs_width
);
    logic [HW-1:0] hs_start_q, hs_end_q;
    logic [VW-1:0] vs_start_q, vs_end_q;

    // Mode copies: follow the inputs while idle, frozen while running.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            htotal_q   <= HW'(DEF_HTOTAL);
            hs_start_q <= HW'(DEF_HS_START);
            hs_end_q   <= HW'(DEF_HS_END);
            vtotal_q   <= VW'(DEF_VTOTAL);
            vs_start_q <= VW'(DEF_VS_START);
            vs_end_q   <= VW'(DEF_VS_END);
        end else if (load) begin
            htotal_q   <= in_htotal;
            hs_start_q <= in_hs_start;
            hs_end_q   <= in_hs_end;
            vtotal_q   <= in_vtotal;
            vs_start_q <= in_vs_start;
            vs_end_q   <= in_vs_end;
        end
    end

    always_comb begin
        hs_width = hs_end_q - hs_start_q;
        scan_pos = htotal_q - hs_end_q;
        vs_width = vs_end_q - vs_start_q;
    end
endmodule

// File: rtl/vsg_wrap_ctr.sv
module vsg_wrap_ctr #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         step,
    input  logic [W-1:0] limit,
    output logic [W-1:0] count,
    output logic         wrap
);
    localparam logic [W-1:0] ONE = W'(1);

    always_comb begin
        wrap = step && (count == (limit - ONE));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clear) begin
            count <= '0;
        end else if (wrap) begin
            count <= '0;
        end else if (step) begin
            count <= count + ONE;
        end
    end
endmodule

// File: rtl/vsg_window.sv
module vsg_window #(
    parameter int W = 12
) (
    input  logic         active,
    input  logic [W-1:0] count,
    input  logic [W-1:0] width,
    output logic         in_win
);
    always_comb begin
        in_win = active && (count < width);
    end
endmodule

// File: rtl/vga_sync_gen.sv
module vga_sync_gen
    import vsg_pkg::*;
#(
    parameter int HW           = 12,
    parameter int VW           = 11,
    parameter int DEF_HTOTAL   = 800,
    parameter int DEF_HS_START = 656,
    parameter int DEF_HS_END   = 720,
    parameter int DEF_VTOTAL   = 497,
    parameter int DEF_VS_START = 481,
    parameter int DEF_VS_END   = 484
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic [HW-1:0] cfg_htotal,
    input  logic [HW-1:0] cfg_hs_start,
    input  logic [HW-1:0] cfg_hs_end,
    input  logic [VW-1:0] cfg_vtotal,
    input  logic [VW-1:0] cfg_vs_start,
    input  logic [VW-1:0] cfg_vs_end,
    output logic          hsync_n,
    output logic          vsync_n,
    output logic [VW-1:0] line_num,
    output logic          scan_start
);
    vsg_state_e    state_q, state_d;
    logic          running, advance, clear, load;
    logic [HW-1:0] htotal_q, hs_width, scan_pos, h_count;
    logic [VW-1:0] vtotal_q, vs_width, v_count;
    logic          h_wrap, v_wrap_unused, h_win, v_win;

    // Next-state logic: start and halt transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (enable)  state_d = ST_RUN;   // start
            ST_RUN:  if (!enable) state_d = ST_IDLE;  // halt
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        running = (state_q == ST_RUN);
        advance = running && enable;
        clear   = !advance;
        load    = (state_q == ST_IDLE);
    end

    vsg_mode_regs #(
        .HW(HW), .VW(VW),
        .DEF_HTOTAL(DEF_HTOTAL), .DEF_HS_START(DEF_HS_START), .DEF_HS_END(DEF_HS_END),
        .DEF_VTOTAL(DEF_VTOTAL), .DEF_VS_START(DEF_VS_START), .DEF_VS_END(DEF_VS_END)
    ) i_mode (
        .clk(clk), .rst_n(rst_n), .load(load),
        .in_htotal(cfg_htotal), .in_hs_start(cfg_hs_start), .in_hs_end(cfg_hs_end),
        .in_vtotal(cfg_vtotal), .in_vs_start(cfg_vs_start), .in_vs_end(cfg_vs_end),
        .htotal_q(htotal_q), .hs_width(hs_width), .scan_pos(scan_pos),
        .vtotal_q(vtotal_q), .vs_width(vs_width)
    );

    // Pixel counter
    vsg_wrap_ctr #(.W(HW)) i_hctr (
        .clk(clk), .rst_n(rst_n), .clear(clear), .step(advance),
        .limit(htotal_q), .count(h_count), .wrap(h_wrap)
    );

    // Line counter, stepped by line-end events
    vsg_wrap_ctr #(.W(VW)) i_vctr (
        .clk(clk), .rst_n(rst_n), .clear(clear), .step(h_wrap),
        .limit(vtotal_q), .count(v_count), .wrap(v_wrap_unused)
    );

    vsg_window #(.W(HW)) i_hwin (
        .active(running), .count(h_count), .width(hs_width), .in_win(h_win)
    );

    vsg_window #(.W(VW)) i_vwin (
        .active(running), .count(v_count), .width(vs_width), .in_win(v_win)
    );

    // Output process
    always_comb begin
        hsync_n    = !h_win;
        vsync_n    = !v_win;
        scan_start = running && (h_count == scan_pos);
        line_num   = v_count;
    end
endmodule

// File: rtl/vsg_sva.sv
module vsg_sva #(
    parameter int HW = 12,
    parameter int VW = 11
) (
    input logic          clk,
    input logic          rst_n,
    input logic          enable,
    input logic          running,
    input logic [HW-1:0] h_count,
    input logic [HW-1:0] htotal_q,
    input logic          hsync_n,
    input logic          vsync_n,
    input logic          scan_start,
    input logic [VW-1:0] line_num
);
    logic mid_line;
    always_comb mid_line = running && enable && (h_count != htotal_q - HW'(1));

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (hsync_n && vsync_n && !scan_start && line_num == '0));

    // R5
    scan_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scan_start |=> !scan_start);

    // R4
    hcount_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (h_count < htotal_q));

    // R6
    line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mid_line |=> $stable(line_num));

    // R7
    vsync_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mid_line |=> $stable(vsync_n));

    // R8
    restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(running) |-> (h_count == '0 && line_num == '0));
endmodule

bind vga_sync_gen vsg_sva #(.HW(HW), .VW(VW)) i_vsg_sva (
    .clk(clk), .rst_n(rst_n), .enable(enable), .running(running),
    .h_count(h_count), .htotal_q(htotal_q), .hsync_n(hsync_n),
    .vsync_n(vsync_n), .scan_start(scan_start), .line_num(line_num)
);

// File: tb/test_vga_sync_gen.sv
module test_vga_sync_gen;
    localparam int HW = 12;
    localparam int VW = 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enable = 1'b0;
    logic [HW-1:0] cfg_htotal = '0, cfg_hs_start = '0, cfg_hs_end = '0;
    logic [VW-1:0] cfg_vtotal = '0, cfg_vs_start = '0, cfg_vs_end = '0;
    logic          hsync_n, vsync_n, scan_start;
    logic [VW-1:0] line_num;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    vga_sync_gen #(.HW(HW), .VW(VW)) i_vga_sync_gen (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .cfg_htotal(cfg_htotal), .cfg_hs_start(cfg_hs_start), .cfg_hs_end(cfg_hs_end),
        .cfg_vtotal(cfg_vtotal), .cfg_vs_start(cfg_vs_start), .cfg_vs_end(cfg_vs_end),
        .hsync_n(hsync_n), .vsync_n(vsync_n), .line_num(line_num), .scan_start(scan_start)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_idle(input string req);
        chk({req, " hsync_n"}, int'(hsync_n), 1);
        chk({req, " vsync_n"}, int'(vsync_n), 1);
        chk({req, " scan_start"}, int'(scan_start), 0);
        chk({req, " line_num"}, int'(line_num), 0);
    endtask

    // Runs one mode for ncyc cycles from a start; optionally scrambles inputs mid-run (R3).
    task automatic run_mode(input int ht, input int hs0, input int hs1,
                            input int vt, input int vs0, input int vs1,
                            input int ncyc, input bit scramble, input string tag);
        @(negedge clk);
        enable       = 1'b0;
        cfg_htotal   = HW'(ht);
        cfg_hs_start = HW'(hs0);
        cfg_hs_end   = HW'(hs1);
        cfg_vtotal   = VW'(vt);
        cfg_vs_start = VW'(vs0);
        cfg_vs_end   = VW'(vs1);
        @(negedge clk);
        chk_idle("R2");
        enable = 1'b1;
        @(negedge clk);
        chk("R8 restart line", int'(line_num), 0);
        chk("R8 restart hsync", int'(hsync_n), (hs1 - hs0) > 0 ? 0 : 1);
        for (int t = 0; t < ncyc; t++) begin
            int p, l;
            p = t % ht;
            l = (t / ht) % vt;
            if (scramble && t == ht + 1) begin
                cfg_htotal   = HW'(ht + 3);
                cfg_hs_end   = HW'(hs1 + 1);
                cfg_vtotal   = VW'(vt + 2);
                cfg_vs_end   = VW'(vs1 + 1);
            end
            chk({tag, "R4 hsync_n"}, int'(hsync_n), (p < hs1 - hs0) ? 0 : 1);
            chk({tag, "R5 scan_start"}, int'(scan_start), (p == ht - hs1) ? 1 : 0);
            chk({tag, "R6 line_num"}, int'(line_num), l);
            chk({tag, "R7 vsync_n"}, int'(vsync_n), (l < vs1 - vs0) ? 0 : 1);
            @(negedge clk);
        end
        enable = 1'b0;
        @(negedge clk);
        chk_idle("R8 halt");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk_idle("R1 in reset");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk_idle("R1 after reset");

        // R2: mode inputs wander while idle, outputs stay quiet
        for (int k = 0; k < 5; k++) begin
            cfg_htotal = HW'(k * 7 + 3);
            cfg_vtotal = VW'(k + 2);
            @(negedge clk);
            chk_idle("R2 idle");
        end

        // Near-exhaustive sweep of small modes, two full frames each
        for (int ht = 4; ht <= 8; ht++)
            for (int hw = 1; hw <= 2; hw++)
                for (int vt = 3; vt <= 5; vt++)
                    for (int vw = 1; vw <= 2; vw++)
                        run_mode(ht, 1, 1 + hw, vt, 1, 1 + vw, 2 * ht * vt, 1'b0, "");

        // R3: inputs changed while running are ignored
        run_mode(6, 1, 3, 4, 2, 3, 3 * 6 * 4, 1'b1, "R3 ");
        run_mode(5, 0, 1, 3, 0, 2, 2 * 5 * 3 + 4, 1'b1, "R3 ");

        // R8: halt mid-frame, then restart from the origin
        run_mode(7, 2, 4, 5, 1, 2, 17, 1'b0, "R8 ");
        run_mode(7, 2, 4, 5, 1, 2, 7 * 5, 1'b0, "R8 ");

        // R9: default mode, three lines
        run_mode(800, 656, 720, 497, 481, 484, 3 * 800, 1'b0, "R9 ");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule